// File: doc/BRIEF.md
# Stack Register Operand Address Generator

This block sits in the decode stage of a register-stack processor. Each instruction of the register-operand or register-compare-and-branch kind carries short operand specifiers: an option bit, an auxiliary bit shared by the instruction and a small register code. The generator turns them into a register-file selector and an index for each operand slot. It also reports the net change the instruction makes to the stack pointer. It does not read or write any register file and performs no arithmetic on operand data.

The generator takes the current stack pointer and local base as inputs. Stack-relative and local-relative indices wrap modulo the stack file depth. Every index is formed from the stack pointer as it stood before the instruction. When more than one operand asks for a pop or a push, the reported stack change is the sum of the requests. Results are registered and appear one clock after the request. They hold their value while no request is presented.

Top module: `sarg_opgen`

## Requirements
- R1: While reset is asserted (rst_n low), out_valid is 0, every file selector reads 3 (none), every index reads 0 and s_delta reads 0.
- R2: out_valid equals in_valid of the previous clock. The selectors, indices and s_delta change only on a clock where in_valid is 1, and otherwise keep their values.
- R3: With option 0 and aux 0, a slot selects file 0 (stack) at index (l_ptr + code) modulo STK_DEPTH.
- R4: With option 0 and aux 1, a slot selects file 1 (auxiliary) at index equal to the code.
- R5: With option 1 and a code below 12, any slot, source or destination, selects file 2 (constants) at index equal to the code.
- R6: For a source slot with option 1, code 12 selects the stack at s_ptr with no stack change, and code 14 selects the stack at s_ptr with a stack change of -1.
- R7: For a source slot with option 1, code 13 selects the stack at s_ptr-1 with no stack change, and code 15 selects the stack at s_ptr-1 with a stack change of -1.
- R8: For the destination slot with option 1, code 12 selects s_ptr and code 13 selects s_ptr-1, both with no stack change. Code 14 selects s_ptr+1 with no stack change, and code 15 selects s_ptr+1 with a stack change of +1.
- R9: When jump_fmt is 1, slot a selects the stack at s_ptr (jmp_sel 0) or at s_ptr-1 (jmp_sel 1). jmp_pop 1 adds -1 to the stack change. Slot b is decoded as a source from b_opt, b_reg and aux. The destination selector reads 3 (none), and dst_opt, dst_reg, a_opt and a_reg have no effect.
- R10: s_delta is the signed sum of all stack changes requested by the slots, within -2 to +1. All indices use s_ptr before that change.
- R11: Stack indices wrap modulo STK_DEPTH: s_ptr-1 at s_ptr 0 gives STK_DEPTH-1, and s_ptr+1 at STK_DEPTH-1 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decode request this cycle |
| jump_fmt | input | 1 | 0: register-operand form, 1: compare-and-branch form |
| aux | input | 1 | Auxiliary bit shared by the specifiers |
| dst_opt | input | 1 | Destination option bit |
| dst_reg | input | REG_W | Destination register code |
| a_opt | input | 1 | First source option bit |
| a_reg | input | REG_W | First source register code |
| b_opt | input | 1 | Second source option bit |
| b_reg | input | REG_W | Second source register code |
| jmp_sel | input | 1 | Branch form: first operand at s_ptr (0) or s_ptr-1 (1) |
| jmp_pop | input | 1 | Branch form: extra pop request |
| s_ptr | input | log2(STK_DEPTH) | Current stack pointer |
| l_ptr | input | log2(STK_DEPTH) | Current local base |
| out_valid | output | 1 | Results valid |
| dst_file | output | 2 | Destination file: 0 stack, 1 aux, 2 const, 3 none |
| dst_idx | output | max(log2(STK_DEPTH), REG_W) | Destination index |
| a_file | output | 2 | First source file |
| a_idx | output | max(log2(STK_DEPTH), REG_W) | First source index |
| b_file | output | 2 | Second source file |
| b_idx | output | max(log2(STK_DEPTH), REG_W) | Second source index |
| s_delta | output | 3 | Signed net stack-pointer change |

## Verification
The bench drives two instances side by side from the same inputs: one at the default depth of 128 and one at a depth of 8. In the small instance, the local base plus a code of up to 15 wraps past the top of the stack file. It also makes the index wider than the stack pointer, so zero extension and wrap are both exercised. The large instance covers the wrap at 0 and 127 for the stack-pointer-relative codes, and the sum of pops and pushes across all three slots.

// File: rtl/sarg_pkg.sv
package sarg_pkg;
    typedef enum logic [1:0] {
        FILE_STK   = 2'd0,
        FILE_AUX   = 2'd1,
        FILE_CONST = 2'd2,
        FILE_NONE  = 2'd3
    } file_e;
endpackage

// File: rtl/sarg_spec_decode.sv
module sarg_spec_decode #(
    parameter int SW     = 7,
    parameter int RW     = 4,
    parameter int IW     = 7,
    parameter bit IS_DST = 1'b0
) (
    input  logic              opt,
    input  logic              aux,
    input  logic [RW-1:0]     code,
    input  logic [SW-1:0]     s_ptr,
    input  logic [SW-1:0]     l_ptr,
    output sarg_pkg::file_e   file,
    output logic [IW-1:0]     idx,
    output logic signed [1:0] delta
);
    import sarg_pkg::*;

    localparam int AW = IW + 1;

    logic [AW-1:0] loc_sum;
    logic [SW-1:0] s_dn;
    logic [SW-1:0] s_up;
    logic          stack_code;
    logic [1:0]    stack_sel;

    assign loc_sum    = AW'(l_ptr) + AW'(code);
    assign s_dn       = s_ptr - SW'(1);
    assign s_up       = s_ptr + SW'(1);
    assign stack_code = &code[RW-1:2];
    assign stack_sel  = code[1:0];

    always_comb begin
        file  = FILE_NONE;
        idx   = '0;
        delta = 2'sb00;
        if (!opt) begin
            if (!aux) begin
                file = FILE_STK;
                idx  = IW'(loc_sum[SW-1:0]);
            end else begin
                file = FILE_AUX;
                idx  = IW'(code);
            end
        end else if (!stack_code) begin
            file = FILE_CONST;
            idx  = IW'(code);
        end else begin
            file = FILE_STK;
            if (IS_DST) begin
                case (stack_sel)
                    2'd0: idx = IW'(s_ptr);
                    2'd1: idx = IW'(s_dn);
                    2'd2: idx = IW'(s_up);
                    default: begin
                        idx   = IW'(s_up);
                        delta = 2'sb01;
                    end
                endcase
            end else begin
                idx   = stack_sel[0] ? IW'(s_dn) : IW'(s_ptr);
                delta = stack_sel[1] ? 2'sb11 : 2'sb00;
            end
        end
    end
endmodule

// File: rtl/sarg_delta_sum.sv
module sarg_delta_sum #(
    parameter int N  = 3,
    parameter int DW = 3
) (
    input  logic signed [1:0]    parts [N],
    output logic signed [DW-1:0] total
);
    logic signed [DW-1:0] acc [N+1];

    assign acc[0] = '0;

    for (genvar g = 0; g < N; g++) begin : g_acc
        assign acc[g+1] = acc[g] + $signed({{(DW-2){parts[g][1]}}, parts[g]});
    end

    assign total = acc[N];
endmodule

// File: rtl/sarg_opgen.sv
module sarg_opgen #(
    parameter int STK_DEPTH = 128,
    parameter int REG_W     = 4,
    localparam int SW = $clog2(STK_DEPTH),
    localparam int IW = (SW > REG_W) ? SW : REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              jump_fmt,
    input  logic              aux,
    input  logic              dst_opt,
    input  logic [REG_W-1:0]  dst_reg,
    input  logic              a_opt,
    input  logic [REG_W-1:0]  a_reg,
    input  logic              b_opt,
    input  logic [REG_W-1:0]  b_reg,
    input  logic              jmp_sel,
    input  logic              jmp_pop,
    input  logic [SW-1:0]     s_ptr,
    input  logic [SW-1:0]     l_ptr,
    output logic              out_valid,
    output logic [1:0]        dst_file,
    output logic [IW-1:0]     dst_idx,
    output logic [1:0]        a_file,
    output logic [IW-1:0]     a_idx,
    output logic [1:0]        b_file,
    output logic [IW-1:0]     b_idx,
    output logic signed [2:0] s_delta
);
    import sarg_pkg::*;

    localparam int DW    = 3;
    localparam int SLOTS = 3;

    typedef struct packed {
        logic              valid;
        logic [1:0]        dst_file;
        logic [IW-1:0]     dst_idx;
        logic [1:0]        a_file;
        logic [IW-1:0]     a_idx;
        logic [1:0]        b_file;
        logic [IW-1:0]     b_idx;
        logic signed [DW-1:0] delta;
    } state_t;

    state_t st_d, st_q;

    file_e             dst_file_w, a_file_w, b_file_w;
    logic [IW-1:0]     dst_idx_w, a_idx_w, b_idx_w;
    logic signed [1:0] dst_dl_w, a_dl_w, b_dl_w;
    logic signed [1:0] parts [SLOTS];
    logic signed [DW-1:0] delta_w;
    logic [SW-1:0]     s_dn;

    assign s_dn = s_ptr - SW'(1);

    sarg_spec_decode #(.SW(SW), .RW(REG_W), .IW(IW), .IS_DST(1'b1)) u_dst (
        .opt(dst_opt), .aux(aux), .code(dst_reg), .s_ptr(s_ptr), .l_ptr(l_ptr),
        .file(dst_file_w), .idx(dst_idx_w), .delta(dst_dl_w)
    );

    sarg_spec_decode #(.SW(SW), .RW(REG_W), .IW(IW), .IS_DST(1'b0)) u_srca (
        .opt(a_opt), .aux(aux), .code(a_reg), .s_ptr(s_ptr), .l_ptr(l_ptr),
        .file(a_file_w), .idx(a_idx_w), .delta(a_dl_w)
    );

    sarg_spec_decode #(.SW(SW), .RW(REG_W), .IW(IW), .IS_DST(1'b0)) u_srcb (
        .opt(b_opt), .aux(aux), .code(b_reg), .s_ptr(s_ptr), .l_ptr(l_ptr),
        .file(b_file_w), .idx(b_idx_w), .delta(b_dl_w)
    );

    always_comb begin
        parts[0] = jump_fmt ? 2'sb00 : dst_dl_w;
        parts[1] = jump_fmt ? (jmp_pop ? 2'sb11 : 2'sb00) : a_dl_w;
        parts[2] = b_dl_w;
    end

    sarg_delta_sum #(.N(SLOTS), .DW(DW)) u_sum (
        .parts(parts),
        .total(delta_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.b_file = b_file_w;
            st_d.b_idx  = b_idx_w;
            st_d.delta  = delta_w;
            if (jump_fmt) begin
                st_d.dst_file = FILE_NONE;
                st_d.dst_idx  = '0;
                st_d.a_file   = FILE_STK;
                st_d.a_idx    = jmp_sel ? IW'(s_dn) : IW'(s_ptr);
            end else begin
                st_d.dst_file = dst_file_w;
                st_d.dst_idx  = dst_idx_w;
                st_d.a_file   = a_file_w;
                st_d.a_idx    = a_idx_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.dst_file <= FILE_NONE;
            st_q.a_file   <= FILE_NONE;
            st_q.b_file   <= FILE_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign dst_file  = st_q.dst_file;
    assign dst_idx   = st_q.dst_idx;
    assign a_file    = st_q.a_file;
    assign a_idx     = st_q.a_idx;
    assign b_file    = st_q.b_file;
    assign b_idx     = st_q.b_idx;
    assign s_delta   = st_q.delta;
endmodule

// File: rtl/sarg_opgen_chk.sv
module sarg_opgen_chk #(
    parameter int SW = 7,
    parameter int RW = 4,
    parameter int IW = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              jump_fmt,
    input logic              aux,
    input logic              dst_opt,
    input logic [RW-1:0]     dst_reg,
    input logic [SW-1:0]     l_ptr,
    input logic              out_valid,
    input logic [1:0]        dst_file,
    input logic [IW-1:0]     dst_idx,
    input logic [1:0]        a_file,
    input logic [IW-1:0]     a_idx,
    input logic [1:0]        b_file,
    input logic [IW-1:0]     b_idx,
    input logic signed [2:0] s_delta
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dst_file) && $stable(dst_idx) && $stable(a_file)
                       && $stable(a_idx) && $stable(b_file) && $stable(b_idx)
                       && $stable(s_delta)));

    // R9
    jump_nodst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && jump_fmt) |=> (dst_file == 2'd3 && a_file == 2'd0));

    // R10
    delta_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (s_delta >= -3'sd2 && s_delta <= 3'sd1));

    // R3
    local_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !jump_fmt && !dst_opt && !aux) |=>
        (dst_file == 2'd0 && dst_idx == IW'(SW'($past(l_ptr) + SW'($past(dst_reg))))));

    // R4
    aux_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !jump_fmt && !dst_opt && aux) |=>
        (dst_file == 2'd1 && dst_idx == IW'($past(dst_reg))));

    // R5
    const_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && a_file == 2'd2) |-> (a_idx < IW'(2**RW - 4)));
endmodule

bind sarg_opgen sarg_opgen_chk #(.SW(SW), .RW(REG_W), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .jump_fmt(jump_fmt),
    .aux(aux), .dst_opt(dst_opt), .dst_reg(dst_reg), .l_ptr(l_ptr),
    .out_valid(out_valid), .dst_file(dst_file), .dst_idx(dst_idx),
    .a_file(a_file), .a_idx(a_idx), .b_file(b_file), .b_idx(b_idx),
    .s_delta(s_delta)
);

// File: tb/sarg_opgen_bench.sv
`timescale 1ns/1ps
module sarg_opgen_bench;
    localparam int BD = 128;
    localparam int SD = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       in_valid = 0, jump_fmt = 0, aux = 0;
    logic       dst_opt = 0, a_opt = 0, b_opt = 0, jmp_sel = 0, jmp_pop = 0;
    logic [3:0] dst_reg = 0, a_reg = 0, b_reg = 0;
    logic [6:0] s_big = 0, l_big = 0;

    logic bo_v, so_v;
    logic [1:0] bd_f, ba_f, bb_f, sd_f, sa_f, sb_f;
    logic [6:0] bd_i, ba_i, bb_i;
    logic [3:0] sd_i, sa_i, sb_i;
    logic signed [2:0] b_del, s_del;

    int nchk = 0;
    int nfail = 0;

    sarg_opgen u_sarg_opgen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .jump_fmt(jump_fmt), .aux(aux),
        .dst_opt(dst_opt), .dst_reg(dst_reg), .a_opt(a_opt), .a_reg(a_reg),
        .b_opt(b_opt), .b_reg(b_reg), .jmp_sel(jmp_sel), .jmp_pop(jmp_pop),
        .s_ptr(s_big), .l_ptr(l_big), .out_valid(bo_v),
        .dst_file(bd_f), .dst_idx(bd_i), .a_file(ba_f), .a_idx(ba_i),
        .b_file(bb_f), .b_idx(bb_i), .s_delta(b_del)
    );

    sarg_opgen #(.STK_DEPTH(SD)) u_sarg_opgen_small (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .jump_fmt(jump_fmt), .aux(aux),
        .dst_opt(dst_opt), .dst_reg(dst_reg), .a_opt(a_opt), .a_reg(a_reg),
        .b_opt(b_opt), .b_reg(b_reg), .jmp_sel(jmp_sel), .jmp_pop(jmp_pop),
        .s_ptr(s_big[2:0]), .l_ptr(l_big[2:0]), .out_valid(so_v),
        .dst_file(sd_f), .dst_idx(sd_i), .a_file(sa_f), .a_idx(sa_i),
        .b_file(sb_f), .b_idx(sb_i), .s_delta(s_del)
    );

    function automatic int wrapi(int base, int off, int d);
        return ((base + off) % d + d) % d;
    endfunction

    task automatic chk(string req, string what, int got, int exp);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // kind 0: stack-relative index (base+off) mod depth; kind 1: plain code index
    task automatic chk_slot(string req, int slot, int ef, int kind, int base, int off);
        int bf, bi, sf, si;
        case (slot)
            0: begin bf = int'(bd_f); bi = int'(bd_i); sf = int'(sd_f); si = int'(sd_i); end
            1: begin bf = int'(ba_f); bi = int'(ba_i); sf = int'(sa_f); si = int'(sa_i); end
            default: begin bf = int'(bb_f); bi = int'(bb_i); sf = int'(sb_f); si = int'(sb_i); end
        endcase
        chk(req, $sformatf("slot%0d file d128", slot), bf, ef);
        chk(req, $sformatf("slot%0d file d8", slot), sf, ef);
        if (ef != 3) begin
            chk(req, $sformatf("slot%0d idx d128", slot), bi, kind ? off : wrapi(base, off, BD));
            chk(req, $sformatf("slot%0d idx d8", slot), si, kind ? off : wrapi(base, off, SD));
        end
    endtask

    task automatic chk_delta(string req, int exp);
        chk(req, "s_delta d128", int'(b_del), exp);
        chk(req, "s_delta d8", int'(s_del), exp);
    endtask

    task automatic drive(bit jf, bit ax, bit dop, int dr, bit aop, int ar,
                         bit bop, int br, bit sel, bit pop, int s, int l);
        in_valid = 1; jump_fmt = jf; aux = ax;
        dst_opt = dop; dst_reg = 4'(dr); a_opt = aop; a_reg = 4'(ar);
        b_opt = bop; b_reg = 4'(br); jmp_sel = sel; jmp_pop = pop;
        s_big = 7'(s); l_big = 7'(l);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "out_valid d128", int'(bo_v), 0);
        chk("R1", "out_valid d8", int'(so_v), 0);
        chk("R1", "dst_file", int'(bd_f), 3);
        chk("R1", "a_file", int'(ba_f), 3);
        chk("R1", "b_file", int'(sb_f), 3);
        chk("R1", "a_idx", int'(ba_i), 0);
        chk_delta("R1", 0);
    endtask

    task automatic t_local();
        drive(0, 0, 0, 5, 0, 15, 0, 0, 0, 0, 10, 126);
        chk("R2", "out_valid", int'(bo_v), 1);
        chk_slot("R3", 0, 0, 0, 126, 5);
        chk_slot("R3", 1, 0, 0, 126, 15);
        chk_slot("R3", 2, 0, 0, 126, 0);
        chk_delta("R3", 0);
    endtask

    task automatic t_aux();
        drive(0, 1, 0, 9, 0, 15, 0, 0, 0, 0, 40, 3);
        chk_slot("R4", 0, 1, 1, 0, 9);
        chk_slot("R4", 1, 1, 1, 0, 15);
        chk_slot("R4", 2, 1, 1, 0, 0);
        chk_delta("R4", 0);
    endtask

    task automatic t_const();
        drive(0, 0, 1, 11, 1, 0, 1, 7, 0, 0, 20, 60);
        chk_slot("R5", 0, 2, 1, 0, 11);
        chk_slot("R5", 1, 2, 1, 0, 0);
        chk_slot("R5", 2, 2, 1, 0, 7);
        chk_delta("R5", 0);
    endtask

    task automatic t_src_stack();
        drive(0, 0, 0, 2, 1, 12, 1, 13, 0, 0, 33, 70);
        chk_slot("R6", 1, 0, 0, 33, 0);
        chk_slot("R7", 2, 0, 0, 33, -1);
        chk_delta("R6", 0);
        drive(0, 0, 0, 2, 1, 14, 1, 15, 0, 0, 33, 70);
        chk_slot("R6", 1, 0, 0, 33, 0);
        chk_slot("R7", 2, 0, 0, 33, -1);
        chk_delta("R7", -2);
        drive(0, 0, 0, 2, 1, 14, 1, 13, 0, 0, 90, 70);
        chk_slot("R6", 1, 0, 0, 90, 0);
        chk_slot("R7", 2, 0, 0, 90, -1);
        chk_delta("R6", -1);
    endtask

    task automatic t_dst_stack();
        int offs[4] = '{0, -1, 1, 1};
        int dls[4]  = '{0, 0, 0, 1};
        for (int k = 0; k < 4; k++) begin
            drive(0, 0, 1, 12 + k, 0, 1, 0, 2, 0, 0, 64, 5);
            chk_slot("R8", 0, 0, 0, 64, offs[k]);
            chk_delta("R8", dls[k]);
        end
    endtask

    task automatic t_jump();
        drive(1, 0, 1, 15, 1, 15, 1, 14, 0, 1, 77, 9);
        chk_slot("R9", 0, 3, 0, 0, 0);
        chk_slot("R9", 1, 0, 0, 77, 0);
        chk_slot("R9", 2, 0, 0, 77, 0);
        chk_delta("R9", -2);
        drive(1, 1, 1, 15, 1, 14, 0, 3, 1, 0, 77, 9);
        chk_slot("R9", 0, 3, 0, 0, 0);
        chk_slot("R9", 1, 0, 0, 77, -1);
        chk_slot("R9", 2, 1, 1, 0, 3);
        chk_delta("R9", 0);
    endtask

    task automatic t_sum();
        drive(0, 0, 1, 15, 1, 14, 1, 15, 0, 0, 50, 0);
        chk_slot("R10", 0, 0, 0, 50, 1);
        chk_slot("R10", 1, 0, 0, 50, 0);
        chk_slot("R10", 2, 0, 0, 50, -1);
        chk_delta("R10", -1);
    endtask

    task automatic t_wrap();
        drive(0, 0, 1, 13, 1, 15, 1, 12, 0, 0, 0, 0);
        chk_slot("R11", 0, 0, 0, 0, -1);
        chk_slot("R11", 1, 0, 0, 0, -1);
        chk_slot("R11", 2, 0, 0, 0, 0);
        drive(0, 0, 1, 14, 1, 12, 1, 12, 0, 0, 127, 0);
        chk_slot("R11", 0, 0, 0, 127, 1);
        chk_slot("R11", 1, 0, 0, 127, 0);
    endtask

    task automatic t_hold();
        drive(0, 1, 0, 6, 1, 3, 1, 14, 0, 0, 30, 0);
        in_valid = 0; aux = 0; dst_reg = 4'd1; a_opt = 0; a_reg = 4'd2;
        b_reg = 4'd12; s_big = 7'd99; l_big = 7'd44;
        @(negedge clk);
        chk("R2", "out_valid after idle d128", int'(bo_v), 0);
        chk("R2", "out_valid after idle d8", int'(so_v), 0);
        chk_slot("R2", 0, 1, 1, 0, 6);
        chk_slot("R2", 1, 2, 1, 0, 3);
        chk_slot("R2", 2, 0, 0, 30, 0);
        chk_delta("R2", -1);
    endtask

    initial begin
        #(200000 * 5);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_local();
        t_aux();
        t_const();
        t_src_stack();
        t_dst_stack();
        t_jump();
        t_sum();
        t_wrap();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule